// File: doc/BRIEF.md
# Converter Status Word with Serial Read-Out

This block keeps the 8-bit status word of a sigma-delta converter and returns it over a serial port. It has four live flags: result ready, result clamped, standby and clock lock. The remaining bits always read as zero. The modulator, the filter, the PLL, the data register and the mode register sit outside the block. They reach it only as strobes and levels, and the block sets and clears its flags from those events.

A host opens a frame by pulling `cs_n` low. It then shifts in a command byte, most significant bit first, one bit per `sck_stb` pulse. A command that asks to read address 0 loads a snapshot of the status word into an output shifter, which then drives `sdo` from bit 7 down to bit 0. A command that asks to read the data address makes the block count the data bits. When the last one has gone out, the ready flag clears. Any other command leaves the block deaf until the frame ends.

Top module: `adcstat_top`

## Requirements
- R1: After reset the status word is 0x00 and `sdo` is 0.
- R2: A command byte with bit 6 = 1 (read) and bits 1:0 = 00 returns the status word MSB first, one bit per `sck_stb`. The layout is bit 7 = ready, bit 3 = clamped, bit 1 = standby, bit 0 = lock, and bits 6, 5, 4 and 2 are zero.
- R3: A `result_wr` pulse sets the ready bit.
- R4: A `pre_update` pulse clears the ready bit.
- R5: A read command to bits 1:0 = 11 clears the ready bit at the last of the DATA_BITS following data bits. A frame that stops short of the last bit leaves the ready bit set.
- R6: A `result_wr` pulse with `result_clamped` high sets the clamped bit. An unclamped result leaves the clamped bit unchanged.
- R7: The clamped bit clears only on a `mode_start` pulse. `pre_update` and data reads do not clear it.
- R8: The standby bit follows `pwr_down` and the lock bit follows `pll_locked`, each one clock later.
- R9: When a set event and a clear event for the same flag fall in the same cycle, the flag ends up set.
- R10: After a command that is a write, or a read of address 01 or 10, the rest of the frame is ignored. `sdo` stays 0 and no flag changes.
- R11: Raising `cs_n` ends any frame. The next frame starts again with a command byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cs_n | input | 1 | Frame select, active low |
| sck_stb | input | 1 | One-cycle pulse per serial bit |
| sdi | input | 1 | Serial data from host |
| sdo | output | 1 | Serial data to host |
| result_wr | input | 1 | New conversion result stored in data register |
| result_clamped | input | 1 | Stored result was clamped (valid with result_wr) |
| pre_update | input | 1 | Pulse a set time before the next result is stored |
| mode_start | input | 1 | Mode bits written to start a conversion |
| pwr_down | input | 1 | Converter is in power-down |
| pll_locked | input | 1 | PLL locked to its reference |

## Verification
The hardest state to reach is one where a flag event collides with its opposite. Examples are a result arriving in the same cycle as the pre-update pulse, or a clamped result arriving in the same cycle as a mode write. Another hard case is a data read that stops one bit short. The vector table drives the colliding strobes together in a single cycle. A directed frame shifts only DATA_BITS-1 data bits and then raises `cs_n`. The flags are always observed through a real status-read frame, never by looking inside.

// File: rtl/adcstat_pkg.sv
`timescale 1ns/1ps
package adcstat_pkg;

  localparam int CMD_W  = 8;
  localparam int WORD_W = 8;

  typedef enum logic [1:0] {
    PH_CMD  = 2'd0,
    PH_STAT = 2'd1,
    PH_DATA = 2'd2,
    PH_SKIP = 2'd3
  } phase_t;

  // Status word layout: ready at 7, clamped at 3, standby at 1, lock at 0.
  function automatic logic [WORD_W-1:0] pack_status(
    input logic rdy, input logic err, input logic stby, input logic lock);
    return {rdy, 3'b000, err, 1'b0, stby, lock};
  endfunction

  // True when a command byte is a read of the given address.
  function automatic logic cmd_reads(
    input logic [CMD_W-1:0] cmd, input int rw_bit, input int addr_w, input int addr);
    logic [CMD_W-1:0] want;
    logic [CMD_W-1:0] mask;
    want = CMD_W'((1 << rw_bit) | addr);
    mask = CMD_W'((1 << rw_bit) | ((1 << addr_w) - 1));
    return ((cmd ^ want) & mask) == '0;
  endfunction

endpackage

// File: rtl/adcstat_flags.sv
`timescale 1ns/1ps
module adcstat_flags
  import adcstat_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              result_wr,
  input  logic              result_clamped,
  input  logic              pre_update,
  input  logic              mode_start,
  input  logic              pwr_down,
  input  logic              pll_locked,
  input  logic              data_done,
  output logic [WORD_W-1:0] status_word
);

  logic rdy_q, err_q, stby_q, lock_q;

  // Named flag events, brought out for the assertions.
  logic rdy_set, rdy_clr, err_set, err_clr;
  assign rdy_set = result_wr;
  assign rdy_clr = pre_update | data_done;
  assign err_set = result_wr & result_clamped;
  assign err_clr = mode_start;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdy_q  <= 1'b0;
      err_q  <= 1'b0;
      stby_q <= 1'b0;
      lock_q <= 1'b0;
    end else begin
      if (rdy_set)      rdy_q <= 1'b1;
      else if (rdy_clr) rdy_q <= 1'b0;
      if (err_set)      err_q <= 1'b1;
      else if (err_clr) err_q <= 1'b0;
      stby_q <= pwr_down;
      lock_q <= pll_locked;
    end
  end

  assign status_word = pack_status(rdy_q, err_q, stby_q, lock_q);

  assert_rdy_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
    result_wr |=> status_word[7]);
  assert_rdy_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (pre_update && !result_wr) |=> !status_word[7]);
  assert_err_with_rdy_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status_word[3]) |-> status_word[7]);
  assert_err_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (status_word[3] && !mode_start) |=> status_word[3]);
  assert_err_set_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (result_wr && result_clamped && mode_start) |=> status_word[3]);
  assert_levels_R8: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (status_word[1] == $past(pwr_down)) && (status_word[0] == $past(pll_locked)));

endmodule

// File: rtl/adcstat_serial.sv
`timescale 1ns/1ps
module adcstat_serial
  import adcstat_pkg::*;
#(
  parameter int DATA_BITS = 16,
  parameter int ADDR_W    = 2,
  parameter int RW_BIT    = 6,
  parameter int STAT_ADDR = 0,
  parameter int DATA_ADDR = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              sck_stb,
  input  logic              sdi,
  input  logic [WORD_W-1:0] status_word,
  output logic              sdo,
  output logic              data_done
);

  localparam int MAX_BITS = (DATA_BITS > CMD_W) ? DATA_BITS : CMD_W;
  localparam int CNT_W    = $clog2(MAX_BITS + 1);
  localparam logic [CNT_W-1:0] CMD_LAST  = CNT_W'(CMD_W - 1);
  localparam logic [CNT_W-1:0] WORD_LAST = CNT_W'(WORD_W - 1);
  localparam logic [CNT_W-1:0] DATA_LAST = CNT_W'(DATA_BITS - 1);

  phase_t             phase;
  logic [CNT_W-1:0]   bitcnt;
  logic [CMD_W-2:0]   cmd_sh;
  logic [WORD_W-1:0]  out_sh;
  logic [CMD_W-1:0]   cmd_next;
  logic               bit_ev;
  logic               cmd_done, stat_done;

  assign bit_ev    = !cs_n && sck_stb;
  assign cmd_next  = {cmd_sh, sdi};
  assign cmd_done  = bit_ev && (phase == PH_CMD)  && (bitcnt == CMD_LAST);
  assign stat_done = bit_ev && (phase == PH_STAT) && (bitcnt == WORD_LAST);
  assign data_done = bit_ev && (phase == PH_DATA) && (bitcnt == DATA_LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase  <= PH_CMD;
      bitcnt <= '0;
      cmd_sh <= '0;
      out_sh <= '0;
    end else if (cs_n) begin
      phase  <= PH_CMD;
      bitcnt <= '0;
    end else if (bit_ev) begin
      unique case (phase)
        PH_CMD: begin
          cmd_sh <= cmd_next[CMD_W-2:0];
          if (cmd_done) begin
            bitcnt <= '0;
            if (cmd_reads(cmd_next, RW_BIT, ADDR_W, STAT_ADDR)) begin
              phase  <= PH_STAT;
              out_sh <= status_word;
            end else if (cmd_reads(cmd_next, RW_BIT, ADDR_W, DATA_ADDR)) begin
              phase  <= PH_DATA;
            end else begin
              phase  <= PH_SKIP;
            end
          end else begin
            bitcnt <= bitcnt + 1'b1;
          end
        end
        PH_STAT: begin
          out_sh <= {out_sh[WORD_W-2:0], 1'b0};
          if (stat_done) begin
            phase  <= PH_CMD;
            bitcnt <= '0;
          end else begin
            bitcnt <= bitcnt + 1'b1;
          end
        end
        PH_DATA: begin
          if (data_done) begin
            phase  <= PH_CMD;
            bitcnt <= '0;
          end else begin
            bitcnt <= bitcnt + 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  assign sdo = (phase == PH_STAT) ? out_sh[WORD_W-1] : 1'b0;

  assert_stat_len_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_STAT) |-> (bitcnt <= WORD_LAST));
  assert_done_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    data_done |=> !data_done);
  assert_skip_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ((phase == PH_SKIP) && !cs_n) |=> (phase == PH_SKIP));
  assert_abort_R11: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |=> ((phase == PH_CMD) && (bitcnt == '0)));

endmodule

// File: rtl/adcstat_top.sv
`timescale 1ns/1ps
module adcstat_top
  import adcstat_pkg::*;
#(
  parameter int DATA_BITS = 16,
  parameter int ADDR_W    = 2,
  parameter int RW_BIT    = 6,
  parameter int STAT_ADDR = 0,
  parameter int DATA_ADDR = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic sck_stb,
  input  logic sdi,
  output logic sdo,
  input  logic result_wr,
  input  logic result_clamped,
  input  logic pre_update,
  input  logic mode_start,
  input  logic pwr_down,
  input  logic pll_locked
);

  logic [WORD_W-1:0] status_word;
  logic              data_done;

  adcstat_flags flags_i (
    .clk            (clk),
    .rst_n          (rst_n),
    .result_wr      (result_wr),
    .result_clamped (result_clamped),
    .pre_update     (pre_update),
    .mode_start     (mode_start),
    .pwr_down       (pwr_down),
    .pll_locked     (pll_locked),
    .data_done      (data_done),
    .status_word    (status_word)
  );

  adcstat_serial #(
    .DATA_BITS (DATA_BITS),
    .ADDR_W    (ADDR_W),
    .RW_BIT    (RW_BIT),
    .STAT_ADDR (STAT_ADDR),
    .DATA_ADDR (DATA_ADDR)
  ) serial_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .cs_n        (cs_n),
    .sck_stb     (sck_stb),
    .sdi         (sdi),
    .status_word (status_word),
    .sdo         (sdo),
    .data_done   (data_done)
  );

  assert_sdo_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n && $past(cs_n)) |-> !sdo);
  assert_done_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (data_done && !result_wr) |=> !status_word[7]);

endmodule

// File: tb/adcstat_top_tb_top.sv
`timescale 1ns/1ps
module adcstat_top_tb_top;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1, sck_stb = 1'b0, sdi = 1'b0;
  logic sdo;
  logic result_wr = 1'b0, result_clamped = 1'b0, pre_update = 1'b0;
  logic mode_start = 1'b0, pwr_down = 1'b0, pll_locked = 1'b0;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  adcstat_top dut_i (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck_stb(sck_stb), .sdi(sdi), .sdo(sdo),
    .result_wr(result_wr), .result_clamped(result_clamped), .pre_update(pre_update),
    .mode_start(mode_start), .pwr_down(pwr_down), .pll_locked(pll_locked)
  );

  // Vector: {result_wr, clamped, pre_update, mode_start, pwr_down, pll_locked, expected word}
  localparam logic [13:0] VEC [10] = '{
    {6'b100001, 8'h81},  // R3 ready sets
    {6'b001001, 8'h01},  // R4 ready clears
    {6'b110001, 8'h89},  // R6 clamped sets with ready
    {6'b001001, 8'h09},  // R7 pre_update leaves clamped
    {6'b100001, 8'h89},  // R6 unclamped result keeps clamped
    {6'b000101, 8'h81},  // R7 mode write clears clamped
    {6'b001010, 8'h02},  // R8 standby on, lock off
    {6'b101010, 8'h82},  // R9 set wins over pre_update
    {6'b110110, 8'h8A},  // R9 clamp set wins over mode write
    {6'b000101, 8'h81}   // R8 levels back
  };

  task automatic check8(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%02h expected=0x%02h", req, act, exp);
    end
  endtask

  task automatic sck(input logic b);
    sdi = b; sck_stb = 1'b1;
    @(negedge clk);
    sck_stb = 1'b0; sdi = 1'b0;
  endtask

  task automatic send_cmd(input logic [7:0] c);
    for (int i = 7; i >= 0; i--) sck(c[i]);
  endtask

  task automatic read_status(output logic [7:0] w);
    cs_n = 1'b0;
    @(negedge clk);
    send_cmd(8'h40);
    for (int i = 7; i >= 0; i--) begin
      w[i] = sdo;
      sck(1'b0);
    end
    cs_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic pulse_result(input logic clamped);
    result_wr = 1'b1; result_clamped = clamped;
    @(negedge clk);
    result_wr = 1'b0; result_clamped = 1'b0;
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] w;
    logic [7:0] seen;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check8("R1 sdo after reset", {7'd0, sdo}, 8'h00);
    read_status(w);
    check8("R1 status after reset", w, 8'h00);

    // Table walk: R2 R3 R4 R6 R7 R8 R9
    for (int v = 0; v < 10; v++) begin
      {result_wr, result_clamped, pre_update, mode_start, pwr_down, pll_locked} = VEC[v][13:8];
      @(negedge clk);
      result_wr = 1'b0; result_clamped = 1'b0; pre_update = 1'b0; mode_start = 1'b0;
      read_status(w);
      check8($sformatf("R2 vector %0d", v), w, VEC[v][7:0]);
    end

    // R5: short data read leaves ready set, full one clears it
    pulse_result(1'b0);
    cs_n = 1'b0; @(negedge clk);
    send_cmd(8'h43);
    for (int i = 0; i < 15; i++) sck(1'b0);
    cs_n = 1'b1; @(negedge clk);
    read_status(w);
    check8("R5 short data read keeps ready", w, 8'h81);
    cs_n = 1'b0; @(negedge clk);
    send_cmd(8'h43);
    for (int i = 0; i < 16; i++) sck(1'b0);
    cs_n = 1'b1; @(negedge clk);
    read_status(w);
    check8("R5 full data read clears ready", w, 8'h01);

    // R7: data read does not clear clamped
    pulse_result(1'b1);
    cs_n = 1'b0; @(negedge clk);
    send_cmd(8'h43);
    for (int i = 0; i < 16; i++) sck(1'b0);
    cs_n = 1'b1; @(negedge clk);
    read_status(w);
    check8("R7 data read keeps clamped", w, 8'h09);
    mode_start = 1'b1; @(negedge clk); mode_start = 1'b0;

    // R10: write command, then bytes that look like commands
    pulse_result(1'b0);
    cs_n = 1'b0; @(negedge clk);
    send_cmd(8'h03);
    seen = 8'h00;
    for (int i = 0; i < 16; i++) begin
      seen[0] = seen[0] | sdo;
      sck((i == 1) || (i == 9) || (i == 14) || (i == 15));
    end
    cs_n = 1'b1; @(negedge clk);
    check8("R10 sdo quiet after write command", seen, 8'h00);
    read_status(w);
    check8("R10 flags untouched after write command", w, 8'h81);

    // R10: read of address 01 is ignored
    cs_n = 1'b0; @(negedge clk);
    send_cmd(8'h41);
    seen = 8'h00;
    for (int i = 0; i < 16; i++) begin
      seen[0] = seen[0] | sdo;
      sck(1'b1);
    end
    cs_n = 1'b1; @(negedge clk);
    check8("R10 sdo quiet after address 01", seen, 8'h00);
    read_status(w);
    check8("R10 ready kept after address 01", w, 8'h81);

    // R11: abort a status read after 3 bits, next frame starts fresh
    cs_n = 1'b0; @(negedge clk);
    send_cmd(8'h40);
    for (int i = 0; i < 3; i++) sck(1'b0);
    cs_n = 1'b1; @(negedge clk);
    check8("R11 sdo low after abort", {7'd0, sdo}, 8'h00);
    read_status(w);
    check8("R11 fresh read after abort", w, 8'h81);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule